// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter, four bits wide by default. On each rising clock edge it can take a parallel load, count one step up or down, or hold its value. All state changes occur together on that edge. There is no asynchronous clear. A known start value is set by a synchronous load.

Counting needs two active-low enables to be low at the same time: a plain count enable and a carry enable. The carry enable also gates a combinational, active-low carry output. That output goes low only when the count sits at its terminal value for the present direction. The terminal value is all ones when counting up and zero when counting down. The carry output can be wired straight into the carry enable of the next stage, so that identical stages form a wider synchronous counter with no extra logic.

Top module: `updn_ctr4`

## Requirements
- R1: When `load_n` is low at a rising edge, `count` takes `load_val` after that edge, whatever the levels of the enables and `up_dn`.
- R2: With `load_n` high, `count` holds at a rising edge if `cnt_en_n` or `carry_en_n` is high.
- R3: With `load_n` high and both enables low, `count` rises by one at the edge when `up_dn` is 1 and falls by one when `up_dn` is 0.
- R4: Counting wraps modulo 2^W. Counting up from all ones gives zero, and counting down from zero gives all ones.
- R5: `carry_n` is 0 exactly when `carry_en_n` is 0 and `count` is at its terminal value (all ones when `up_dn` is 1, zero when `up_dn` is 0). `cnt_en_n` has no effect on `carry_n`.
- R6: `carry_n` is combinational. If `up_dn` or `carry_en_n` changes while the clock is steady, `carry_n` follows within the same clock phase.
- R7: Two stages form a 2W-bit synchronous counter in both directions when the low stage's `carry_n` drives the high stage's `carry_en_n` and all other inputs are shared.
- R8: Pulses on `load_n`, `cnt_en_n` and `load_val` that start and end between two rising edges leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_n | input | 1 | Count enable, active low; does not affect the carry output |
| carry_en_n | input | 1 | Count enable that also gates the carry output, active low |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| load_val | input | W | Parallel load value |
| count | output | W | Registered count |
| carry_n | output | 1 | Terminal-count carry, active low, combinational |

## Verification
Load and count can both be requested at the same edge. The bench provokes this by pulling `load_n` low while both enables are low and the count sits at a carry boundary. A correct result is that the loaded value appears and the step is dropped. The terminal carry and a count step also fall in the same cycle at every carry boundary of a two-stage cascade. There the high stage must step exactly when the low stage wraps. The bench judges this against an 8-bit reference counter, compared on every clock in both directions.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } ctr_op_e;

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import updn_ctr_pkg::*;
(
    input  logic    load_n,
    input  logic    cnt_en_n,
    input  logic    carry_en_n,
    input  logic    up_dn,
    output ctr_op_e op
);
    // Load has priority; a step needs both enables low.
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (!cnt_en_n && !carry_en_n) begin
            op = up_dn ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/ctr_step.sv
module ctr_step
    import updn_ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  ctr_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   load_val,
    output logic [W-1:0]   nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Wrapping is natural: W-bit arithmetic drops the carry out.
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = load_val;
            OP_INC:  nxt = cur + ONE;
            OP_DEC:  nxt = cur - ONE;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_term_carry.sv
module ctr_term_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         carry_en_n,
    input  logic         up_dn,
    output logic         carry_n
);
    logic at_max;
    logic at_min;
    logic at_term;

    always_comb begin
        at_max  = &cur;
        at_min  = ~|cur;
        at_term = up_dn ? at_max : at_min;
        carry_n = ~(at_term & ~carry_en_n);
    end
endmodule

// File: rtl/updn_ctr4.sv
module updn_ctr4
    import updn_ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         load_n,
    input  logic         cnt_en_n,
    input  logic         carry_en_n,
    input  logic         up_dn,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         carry_n
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ALL_ZERO = {W{1'b0}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d;
    ctr_state_t st_q;
    ctr_op_e    op;
    logic [W-1:0] cnt_nxt;

    ctr_op_decode u_dec (
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .carry_en_n (carry_en_n),
        .up_dn      (up_dn),
        .op         (op)
    );

    ctr_step #(.W(W)) u_step (
        .op       (op),
        .cur      (st_q.cnt),
        .load_val (load_val),
        .nxt      (cnt_nxt)
    );

    ctr_term_carry #(.W(W)) u_carry (
        .cur        (st_q.cnt),
        .carry_en_n (carry_en_n),
        .up_dn      (up_dn),
        .carry_n    (carry_n)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // Checking is armed once a load has made the count known.
    logic chk_arm_q = 1'b0;
    always_ff @(posedge clk) begin
        chk_arm_q <= chk_arm_q | ~load_n;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!chk_arm_q)
        !load_n |=> count == $past(load_val)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!chk_arm_q)
        (load_n && (cnt_en_n || carry_en_n)) |=> $stable(count)); // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!chk_arm_q)
        (load_n && !cnt_en_n && !carry_en_n && up_dn) |=> count == $past(count) + ONE); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!chk_arm_q)
        (load_n && !cnt_en_n && !carry_en_n && !up_dn) |=> count == $past(count) - ONE); // R3
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (!chk_arm_q)
        (load_n && !cnt_en_n && !carry_en_n && up_dn && count == ALL_ONES) |=> count == ALL_ZERO); // R4
    AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!chk_arm_q)
        !carry_n |-> !carry_en_n); // R5
    AST_CARRY_TERM: assert property (@(posedge clk) disable iff (!chk_arm_q)
        !carry_n |-> (count == (up_dn ? ALL_ONES : ALL_ZERO))); // R5
endmodule

// File: tb/tb_updn_ctr4.sv
`timescale 1ns/1ps
module tb_updn_ctr4;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       load_n = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       carry_en_n = 1'b1;
    logic       up_dn = 1'b1;
    logic [7:0] din = 8'h00;
    logic [3:0] lo_q, hi_q;
    logic       lo_carry_n, hi_carry_n;

    int ref8 = -1;
    int checks = 0;
    int errors = 0;

    updn_ctr4 #(.W(4)) dut (
        .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .carry_en_n(carry_en_n),
        .up_dn(up_dn), .load_val(din[3:0]), .count(lo_q), .carry_n(lo_carry_n)
    );

    updn_ctr4 #(.W(4)) dut_hi (
        .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .carry_en_n(lo_carry_n),
        .up_dn(up_dn), .load_val(din[7:4]), .count(hi_q), .carry_n(hi_carry_n)
    );

    // Behavioural 8-bit reference, updated on the edge from the inputs seen there.
    always @(posedge clk) begin
        if (!load_n) ref8 <= int'(din);
        else if (!cnt_en_n && !carry_en_n && ref8 >= 0)
            ref8 <= up_dn ? (ref8 + 1) % 256 : (ref8 + 255) % 256;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lo_carry();
        if (carry_en_n) return 1;
        if (up_dn) return ((ref8 & 15) == 15) ? 0 : 1;
        return ((ref8 & 15) == 0) ? 0 : 1;
    endfunction

    function automatic int exp_hi_carry();
        if (carry_en_n) return 1;
        if (up_dn) return (ref8 == 255) ? 0 : 1;
        return (ref8 == 0) ? 0 : 1;
    endfunction

    // Compare every clock, in the low phase before the inputs move.
    always @(negedge clk) begin
        if (ref8 >= 0) begin
            chk("R7 cascade count (R1 R2 R3 R4)", int'({hi_q, lo_q}), ref8);
            chk("R5 low stage carry", int'(lo_carry_n), exp_lo_carry());
            chk("R7 high stage carry", int'(hi_carry_n), exp_hi_carry());
        end
    end

    task automatic cyc(input int n, input logic ld, input logic p, input logic t,
                       input logic u, input logic [7:0] d);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            load_n = ld; cnt_en_n = p; carry_en_n = t; up_dn = u; din = d;
        end
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int saved;
        // First load gives the known start value.
        cyc(1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
        cyc(1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R1 initial load", int'({hi_q, lo_q}), 0);

        // Up through every carry and the 255->0 wrap, then down likewise.
        cyc(300, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        cyc(300, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

        // Hold with either enable high.
        cyc(5, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(5, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);

        // Load with counting requested at a carry boundary: load must win.
        cyc(1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF);
        cyc(1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5);
        cyc(1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R1 load over count", int'({hi_q, lo_q}), 8'hA5);
        cyc(1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C);
        cyc(1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R1 load with enables high", int'({hi_q, lo_q}), 8'h3C);

        // Combinational carry at zero and at all ones, no clock edge.
        cyc(1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        @(negedge clk); #1;
        up_dn = 1'b0; #1;
        chk("R6 carry at zero counting down", int'(lo_carry_n), 0);
        up_dn = 1'b1; #1;
        chk("R6 carry at zero counting up", int'(lo_carry_n), 1);
        up_dn = 1'b0; cnt_en_n = 1'b0; carry_en_n = 1'b1; #1;
        chk("R6 carry follows carry_en_n", int'(lo_carry_n), 1);
        carry_en_n = 1'b0; cnt_en_n = 1'b1; #1;
        chk("R5 cnt_en_n has no effect on carry", int'(lo_carry_n), 0);
        cyc(1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F);
        cyc(1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        @(negedge clk); #1;
        chk("R6 carry at all ones counting up", int'(lo_carry_n), 0);
        up_dn = 1'b0; #1;
        chk("R6 carry at all ones counting down", int'(lo_carry_n), 1);
        up_dn = 1'b1;

        // Pulses between edges must not disturb the count.
        saved = int'({hi_q, lo_q});
        @(posedge clk); #2;
        load_n = 1'b0; cnt_en_n = 1'b0; din = 8'h33; #2;
        load_n = 1'b1; cnt_en_n = 1'b1; din = 8'h00;
        @(negedge clk); #1;
        chk("R8 mid-cycle pulse ignored", int'({hi_q, lo_q}), saved);
        @(posedge clk); #2;
        load_n = 1'b0; din = 8'hC3; #2;
        load_n = 1'b1;
        @(negedge clk); #1;
        chk("R8 second pulse ignored", int'({hi_q, lo_q}), saved);

        // Mixed directions across a boundary.
        cyc(1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0E);
        for (int k = 0; k < 8; k++) begin
            cyc(3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
            cyc(2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        end
        cyc(3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule